// File: doc/BRIEF.md
# Repeated String Operation Pointer Sequencer

This block drives the address side of a repeated block-memory operation. It keeps a source index, a destination index and an iteration count. When started, it presents the current source and destination offsets to the memory side, one element at a time. Each time the memory side acknowledges an element, both indices move by one element size. The indices move up or down according to a direction input. The block does not move data, form segmented addresses or decode instructions.

Software-visible state is loaded through a single load strobe while the block is idle. A start pulse then runs either one element or a repeated sequence. In a repeated sequence the count is tested for zero before any element is issued, and it is decremented on every acknowledged element until it reaches zero. A one-cycle completion pulse marks the end of each operation.

Top module: `strop_seq`

## Requirements
- R1: After reset both indices and the count are 0, and `busy`, `elem_req` and `done` are all low.
- R2: While idle, `ld` writes `src_init`, `dst_init` and `cnt_init` into the registers on the next edge, and a `start` in the same cycle is ignored. While busy, `ld` has no effect.
- R3: With `dir_down`=0 and `wide`=0 (byte), each acknowledged element adds 1 to both indices.
- R4: With `wide`=1 (word) the step is 2. With `dir_down`=1 the indices are decremented instead of incremented.
- R5: Both indices wrap modulo 2^16 in either direction.
- R6: With `rep`=1 and a count N>0, exactly N elements are issued. The count drops by 1 on each acknowledge and ends at 0, so a count of 10 gives exactly 10 elements.
- R7: With `rep`=1 and a count of 0 at start, no element is requested, and `done` is high in the cycle after the start.
- R8: With `rep`=0, exactly one element is issued and the count register keeps its value.
- R9: While an element is requested and not acknowledged, the indices and the count hold their values.
- R10: `done` is high for exactly one cycle, after the acknowledge of the last element. In that cycle `busy` and `elem_req` are low.
- R11: While `elem_req` is high, `src_off` and `dst_off` carry the indices of the current element. `elem_req` rises in the cycle after an accepted start.
- R12: `wide`, `dir_down` and `rep` are captured at start. Changing them during a run has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld | input | 1 | Load the indices and the count (idle only) |
| src_init | input | 16 | Source index load value |
| dst_init | input | 16 | Destination index load value |
| cnt_init | input | 16 | Count load value |
| start | input | 1 | Begin an operation (idle only) |
| rep | input | 1 | 1: repeat under count control, 0: single element |
| wide | input | 1 | Element size: 0 byte, 1 word |
| dir_down | input | 1 | 1: indices decrement, 0: increment |
| elem_ack | input | 1 | Memory side accepts the current element |
| elem_req | output | 1 | An element is pending on the offsets |
| src_off | output | 16 | Current source index |
| dst_off | output | 16 | Current destination index |
| cnt_val | output | 16 | Current count |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Every result is one register stage away from its cause. After the edge that accepts a start, `elem_req` and `busy` are valid. After an acknowledging edge, the moved indices and the decremented count are valid. After the edge with the last acknowledge, or after an empty repeated start, `done` is valid. The bench drives inputs on the falling edge and samples on the next falling edge, which is exactly one register stage after the rising edge that acted on them. Ordinary loads are checked at that same point. Stalls are held for a varying number of cycles, and the offsets are compared at every stalled cycle.

// File: rtl/strop_pkg.sv
package strop_pkg;
   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_e;

   typedef struct packed {
      logic down;
      logic wide;
      logic rep;
   } op_mode_t;
endpackage

// File: rtl/strop_idx.sv
module strop_idx #(
   parameter int W       = 16,
   parameter bit WORD_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   input  logic         adv,
   input  logic         down,
   input  logic         wide,
   output logic [W-1:0] q
);
   logic [W-1:0] step;

   generate
      if (WORD_EN) begin : g_sized
         assign step = wide ? W'(2) : W'(1);
      end else begin : g_byte_only
         logic unused_wide;
         assign unused_wide = wide;
         assign step = W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)   q <= '0;
      else if (ld)  q <= ld_val;
      else if (adv) q <= down ? (q - step) : (q + step);
   end
endmodule

// File: rtl/strop_cnt.sv
module strop_cnt #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   input  logic         dec,
   output logic [W-1:0] q,
   output logic         is_zero,
   output logic         is_one
);
   always_ff @(posedge clk) begin
      if (!rst_n)   q <= '0;
      else if (ld)  q <= ld_val;
      else if (dec) q <= q - W'(1);
   end

   assign is_zero = (q == '0);
   assign is_one  = (q == W'(1));
endmodule

// File: rtl/strop_ctrl.sv
module strop_ctrl
   import strop_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     start,
   input  logic     ld,
   input  logic     rep,
   input  logic     wide,
   input  logic     down,
   input  logic     cnt_zero,
   input  logic     cnt_one,
   input  logic     ack,
   output logic     busy,
   output logic     req,
   output logic     done,
   output logic     adv,
   output logic     dec,
   output op_mode_t mode
);
   seq_state_e state_q;
   op_mode_t   mode_q;
   logic       done_q;
   logic       go, empty, fire, last;

   assign go    = (state_q == SEQ_IDLE) && start && !ld;
   assign empty = go && rep && cnt_zero;
   assign fire  = (state_q == SEQ_RUN) && ack;
   assign last  = !mode_q.rep || cnt_one;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         mode_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= empty || (fire && last);
         case (state_q)
            SEQ_IDLE:
               if (go && !empty) begin
                  state_q <= SEQ_RUN;
                  mode_q  <= '{down: down, wide: wide, rep: rep};
               end
            SEQ_RUN:
               if (fire && last) state_q <= SEQ_IDLE;
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign busy = (state_q == SEQ_RUN);
   assign req  = busy;
   assign done = done_q;
   assign adv  = fire;
   assign dec  = fire && mode_q.rep;
   assign mode = mode_q;
endmodule

// File: rtl/strop_seq.sv
module strop_seq
   import strop_pkg::*;
#(
   parameter int IDX_W   = 16,
   parameter int CNT_W   = 16,
   parameter bit WORD_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld,
   input  logic [IDX_W-1:0] src_init,
   input  logic [IDX_W-1:0] dst_init,
   input  logic [CNT_W-1:0] cnt_init,
   input  logic             start,
   input  logic             rep,
   input  logic             wide,
   input  logic             dir_down,
   input  logic             elem_ack,
   output logic             elem_req,
   output logic [IDX_W-1:0] src_off,
   output logic [IDX_W-1:0] dst_off,
   output logic [CNT_W-1:0] cnt_val,
   output logic             busy,
   output logic             done
);
   localparam int N_IDX = 2;

   generate
      if (IDX_W < 2) begin : g_bad_idx
         $error("strop_seq: IDX_W must be at least 2");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("strop_seq: CNT_W must be at least 1");
      end
   endgenerate

   op_mode_t         mode;
   logic             adv, dec, cnt_zero, cnt_one, ld_ok;
   logic [IDX_W-1:0] idx_init [N_IDX];
   logic [IDX_W-1:0] idx_q    [N_IDX];

   assign ld_ok       = ld && !busy;
   assign idx_init[0] = src_init;
   assign idx_init[1] = dst_init;

   strop_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .ld       (ld),
      .rep      (rep),
      .wide     (wide),
      .down     (dir_down),
      .cnt_zero (cnt_zero),
      .cnt_one  (cnt_one),
      .ack      (elem_ack),
      .busy     (busy),
      .req      (elem_req),
      .done     (done),
      .adv      (adv),
      .dec      (dec),
      .mode     (mode)
   );

   for (genvar i = 0; i < N_IDX; i++) begin : g_idx
      strop_idx #(.W(IDX_W), .WORD_EN(WORD_EN)) u_idx (
         .clk    (clk),
         .rst_n  (rst_n),
         .ld     (ld_ok),
         .ld_val (idx_init[i]),
         .adv    (adv),
         .down   (mode.down),
         .wide   (mode.wide),
         .q      (idx_q[i])
      );
   end

   strop_cnt #(.W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld      (ld_ok),
      .ld_val  (cnt_init),
      .dec     (dec),
      .q       (cnt_val),
      .is_zero (cnt_zero),
      .is_one  (cnt_one)
   );

   assign src_off = idx_q[0];
   assign dst_off = idx_q[1];
endmodule

// File: rtl/strop_seq_chk.sv
module strop_seq_chk #(
   parameter int IDX_W = 16,
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ld,
   input logic             start,
   input logic             rep,
   input logic             elem_ack,
   input logic             elem_req,
   input logic [IDX_W-1:0] src_off,
   input logic [IDX_W-1:0] dst_off,
   input logic [CNT_W-1:0] cnt_val,
   input logic             busy,
   input logic             done
);
   // R7: an empty repeated start finishes with no element
   assert_empty_rep_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && !ld && rep && cnt_val == '0) |=> (done && !elem_req));

   // R9: a stalled element leaves the state untouched
   assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !elem_ack) |=> ($stable(src_off) && $stable(dst_off) && $stable(cnt_val)));

   // R10: the completion pulse never overlaps a pending element
   assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !elem_req));

   // R6: acknowledging with a count of one ends the run
   assert_last_elem_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && elem_ack && cnt_val == CNT_W'(1)) |=> (!busy && done));

   // R10: the completion pulse lasts a single cycle
   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

bind strop_seq strop_seq_chk #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ld       (ld),
   .start    (start),
   .rep      (rep),
   .elem_ack (elem_ack),
   .elem_req (elem_req),
   .src_off  (src_off),
   .dst_off  (dst_off),
   .cnt_val  (cnt_val),
   .busy     (busy),
   .done     (done)
);

// File: tb/sim_strop_seq.sv
`timescale 1ns/1ps
module sim_strop_seq;
   typedef struct packed {
      logic [15:0] src;
      logic [15:0] dst;
      logic [15:0] cnt;
      logic        rep;
      logic        wide;
      logic        down;
      logic [15:0] n_elem;
      logic [15:0] src_end;
      logic [15:0] dst_end;
      logic [15:0] cnt_end;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t TBL [NV] = '{
      '{16'h0100, 16'h0200, 16'd3,  1'b1, 1'b0, 1'b0, 16'd3,  16'h0103, 16'h0203, 16'd0},
      '{16'h1000, 16'h2000, 16'd4,  1'b1, 1'b1, 1'b1, 16'd4,  16'h0FF8, 16'h1FF8, 16'd0},
      '{16'hFFFF, 16'h0000, 16'd2,  1'b1, 1'b1, 1'b0, 16'd2,  16'h0003, 16'h0004, 16'd0},
      '{16'h0001, 16'h0000, 16'd3,  1'b1, 1'b0, 1'b1, 16'd3,  16'hFFFE, 16'hFFFD, 16'd0},
      '{16'h0050, 16'h0060, 16'd7,  1'b0, 1'b1, 1'b0, 16'd1,  16'h0052, 16'h0062, 16'd7},
      '{16'h0000, 16'h0000, 16'd0,  1'b1, 1'b0, 1'b0, 16'd0,  16'h0000, 16'h0000, 16'd0},
      '{16'h0300, 16'h0400, 16'd10, 1'b1, 1'b0, 1'b0, 16'd10, 16'h030A, 16'h040A, 16'd0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld = 1'b0, start = 1'b0, rep = 1'b0, wide = 1'b0, dir_down = 1'b0;
   logic        elem_ack = 1'b0;
   logic [15:0] src_init = '0, dst_init = '0, cnt_init = '0;
   logic        elem_req, busy, done;
   logic [15:0] src_off, dst_off, cnt_val;
   int          n_cmp = 0;
   int          n_bad = 0;

   always #4 clk = ~clk;

   strop_seq u0 (
      .clk(clk), .rst_n(rst_n), .ld(ld), .src_init(src_init), .dst_init(dst_init),
      .cnt_init(cnt_init), .start(start), .rep(rep), .wide(wide), .dir_down(dir_down),
      .elem_ack(elem_ack), .elem_req(elem_req), .src_off(src_off), .dst_off(dst_off),
      .cnt_val(cnt_val), .busy(busy), .done(done)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   task automatic load_regs(input logic [15:0] s, input logic [15:0] d, input logic [15:0] c);
      @(negedge clk);
      ld = 1'b1; src_init = s; dst_init = d; cnt_init = c;
      @(negedge clk);
      ld = 1'b0;
   endtask

   task automatic run_vec(input vec_t v, input int stall_base);
      logic [15:0] es, ed, ec, step;
      load_regs(v.src, v.dst, v.cnt);
      chk("R2 src load", {16'h0, src_off}, {16'h0, v.src});
      chk("R2 cnt load", {16'h0, cnt_val}, {16'h0, v.cnt});
      es = v.src; ed = v.dst; ec = v.cnt;
      step = v.wide ? 16'd2 : 16'd1;
      start = 1'b1; rep = v.rep; wide = v.wide; dir_down = v.down;
      @(negedge clk);
      start = 1'b0;
      // R12: flip the mode inputs for the rest of the run
      wide = ~v.wide; dir_down = ~v.down; rep = ~v.rep;
      if (v.n_elem == 0) begin
         chk("R7 no request", {31'h0, elem_req}, 32'h0);
         chk("R7 done", {31'h0, done}, 32'h1);
      end
      for (int e = 0; e < int'(v.n_elem); e++) begin
         chk("R11 req", {31'h0, elem_req}, 32'h1);
         if (elem_req !== 1'b1) break;
         for (int k = 0; k < (e + stall_base) % 3; k++) begin
            @(negedge clk);
            chk("R9 stall src", {16'h0, src_off}, {16'h0, es});
            chk("R9 stall cnt", {16'h0, cnt_val}, {16'h0, ec});
         end
         chk("R11 src offset", {16'h0, src_off}, {16'h0, es});
         chk("R11 dst offset", {16'h0, dst_off}, {16'h0, ed});
         elem_ack = 1'b1;
         @(negedge clk);
         elem_ack = 1'b0;
         es = v.down ? es - step : es + step;
         ed = v.down ? ed - step : ed + step;
         if (v.rep) ec = ec - 16'd1;
         if (e == int'(v.n_elem) - 1) begin
            chk("R10 done after last", {31'h0, done}, 32'h1);
            chk("R10 busy low", {31'h0, busy}, 32'h0);
         end else begin
            chk("R6 count step", {16'h0, cnt_val}, {16'h0, ec});
         end
      end
      @(negedge clk);
      chk("R10 single pulse", {31'h0, done}, 32'h0);
      chk("R6/R8 no extra element", {31'h0, elem_req}, 32'h0);
      chk("R3/R4/R5 src end", {16'h0, src_off}, {16'h0, v.src_end});
      chk("R3/R4/R5 dst end", {16'h0, dst_off}, {16'h0, v.dst_end});
      chk("R6/R8 count end", {16'h0, cnt_val}, {16'h0, v.cnt_end});
      wide = 1'b0; dir_down = 1'b0; rep = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset values
      chk("R1 src", {16'h0, src_off}, 32'h0);
      chk("R1 dst", {16'h0, dst_off}, 32'h0);
      chk("R1 cnt", {16'h0, cnt_val}, 32'h0);
      chk("R1 ctl", {29'h0, busy, elem_req, done}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) run_vec(TBL[i], i);

      // R2: load while busy has no effect; start with load is ignored
      load_regs(16'h0A00, 16'h0B00, 16'd2);
      start = 1'b1; rep = 1'b1; ld = 1'b1;
      src_init = 16'h1234; dst_init = 16'h5678; cnt_init = 16'd9;
      @(negedge clk);
      start = 1'b0; ld = 1'b0;
      chk("R2 start ignored under load", {31'h0, busy}, 32'h0);
      chk("R2 load with start", {16'h0, src_off}, 32'h1234);
      load_regs(16'h0A00, 16'h0B00, 16'd2);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      ld = 1'b1; src_init = 16'hDEAD; dst_init = 16'hBEEF; cnt_init = 16'd50;
      @(negedge clk);
      ld = 1'b0;
      chk("R2 busy load src", {16'h0, src_off}, 32'h0A00);
      chk("R2 busy load cnt", {16'h0, cnt_val}, 32'h2);
      elem_ack = 1'b1;
      @(negedge clk);
      @(negedge clk);
      elem_ack = 1'b0;
      chk("R2 end src", {16'h0, src_off}, 32'h0A02);
      chk("R2 end dst", {16'h0, dst_off}, 32'h0B02);
      chk("R2 end cnt", {16'h0, cnt_val}, 32'h0);
      rep = 1'b0;
      @(negedge clk);
      finish_run();
   end
endmodule